// File: doc/BRIEF.md
# Dual Palette Lookup Unit

This block keeps two colour palettes of 256 words each, one serving a background pixel stream and one serving a foreground pixel stream. Each palette word is a 32-bit ARGB colour (alpha in bits 31:24, then red, green and blue). A pixel stream presents an index and gets back the stored colour one cycle later. The index is either a full 8-bit value or a short 4-bit value. A short index reaches only the first sixteen entries.

The palettes are loaded through a simple write port. A mode input picks how a write is placed. In direct mode the write address names the entry. In streaming mode each palette has a write pointer that steps forward after every accepted word. Each palette has two controls of its own. One wipes the contents to zero. The other returns the streaming pointer to entry 0. A gate input must be high for any write or lookup to take effect.

Top module: `dual_palette_lut`

## Requirements
- R1: After reset both colour outputs read 0, both valid outputs and both busy outputs are 0, and both streaming pointers are at entry 0.
- R2: With `direct_mode`=1, a write whose `bus_addr[11:10]` is 01 stores `bus_wdata` in background entry `bus_addr[9:2]`, and 10 stores it in the foreground entry. A write is ignored when bits 11:10 are 00 or 11, or when `bus_addr[1:0]` is not 00.
- R3: With `direct_mode`=0, an accepted write to window 01 (background) or 10 (foreground) stores the word at that palette's pointer, whatever `bus_addr[9:2]` holds. The pointer then steps by one and wraps from 255 to 0.
- R4: While a palette's pointer reset input is high, its pointer is forced to 0 and streaming writes to that palette are ignored. The palette contents are kept.
- R5: A rising edge on a palette's clear input sets its busy output for exactly 256 cycles. During that time every entry is written to 0 and host writes to that palette are ignored. The other palette is left alone.
- R6: A full-index lookup presented in one cycle gives the entry's colour on the colour output, with valid high, after the next clock edge.
- R7: When the short-index input is 1, only index bits 3:0 are used, zero-extended. Index bits 7:4 have no effect.
- R8: While `gate_en` is 0, writes are ignored, lookups raise no valid, and the colour outputs hold their value.
- R9: In a cycle with no accepted lookup, the valid output falls to 0 and the colour output keeps its last value.
- R10: A lookup and a write to the same entry in the same cycle return the entry's old contents. The new word is seen by later lookups.
- R11: The two palettes are independent. The same index yields each palette's own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Enables palette writes and lookups |
| direct_mode | input | 1 | 1 selects direct addressing, 0 selects the streaming pointer |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address: bits 11:10 pick the palette, bits 9:2 the entry |
| bus_wdata | input | 32 | ARGB word to store |
| bg_clr | input | 1 | Background contents wipe, started on a rising edge |
| fg_clr | input | 1 | Foreground contents wipe, started on a rising edge |
| bg_ptr_rst | input | 1 | Holds the background streaming pointer at 0 |
| fg_ptr_rst | input | 1 | Holds the foreground streaming pointer at 0 |
| bg_vld | input | 1 | Background lookup request |
| bg_idx | input | 8 | Background pixel index |
| bg_short | input | 1 | Background index is 4-bit |
| fg_vld | input | 1 | Foreground lookup request |
| fg_idx | input | 8 | Foreground pixel index |
| fg_short | input | 1 | Foreground index is 4-bit |
| bg_argb_vld | output | 1 | Background colour valid |
| bg_argb | output | 32 | Background colour |
| fg_argb_vld | output | 1 | Foreground colour valid |
| fg_argb | output | 32 | Foreground colour |
| bg_busy | output | 1 | Background wipe in progress |
| fg_busy | output | 1 | Foreground wipe in progress |

## Verification
A host write and a pixel lookup can hit the same palette entry in the same clock. The bench drives both in one cycle to background entry 10. It expects the old word on the colour output and then the new word on a second lookup. A wipe in progress and a host write can also meet. The bench issues a write to foreground entry 30 in the middle of the 256 busy cycles. It judges the result by reading entry 30 as zero once busy has fallen, and by counting exactly 256 busy cycles.

// File: rtl/lut_pkg.sv
package lut_pkg;

  localparam int unsigned NUM_TBL = 2;
  localparam int unsigned WIN_W   = 2;

  typedef enum logic {
    TBL_BACK = 1'b0,
    TBL_FORE = 1'b1
  } tbl_sel_e;

  // Window code in the upper address bits that selects palette t.
  function automatic logic [WIN_W-1:0] win_code(input int unsigned t);
    return WIN_W'(t + 1);
  endfunction

endpackage

// File: rtl/lut_host_port.sv
module lut_host_port
  import lut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              gate_en,
  input  logic                              direct_mode,
  input  logic                              wr_en,
  input  logic [IDX_W+3:0]                  wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [NUM_TBL-1:0]                ptr_rst,
  input  logic [NUM_TBL-1:0]                busy,
  output logic [NUM_TBL-1:0]                tbl_we,
  output logic [NUM_TBL-1:0][IDX_W-1:0]     tbl_waddr,
  output logic [DATA_W-1:0]                 tbl_wdata
);

  localparam int unsigned WIN_LSB = IDX_W + 2;

  logic [WIN_W-1:0] win;
  logic             aligned;

  assign win       = wr_addr[WIN_LSB +: WIN_W];
  assign aligned   = (wr_addr[1:0] == 2'b00);
  assign tbl_wdata = wr_data;

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_d;
    logic             hit;
    logic             fifo_blk;
    logic             accept;

    always_comb begin
      hit      = wr_en & gate_en & aligned & (win == win_code(t));
      fifo_blk = ~direct_mode & ptr_rst[t];
      accept   = hit & ~busy[t] & ~fifo_blk;
      ptr_d    = ptr_q;
      if (ptr_rst[t]) begin
        ptr_d = '0;
      end else if (accept && !direct_mode) begin
        ptr_d = ptr_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else begin
        ptr_q <= ptr_d;
      end
    end

    assign tbl_we[t]    = accept;
    assign tbl_waddr[t] = direct_mode ? wr_addr[2 +: IDX_W] : ptr_q;
  end

endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned L4_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic              clr_req,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_vld,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_short,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              busy
);

  localparam int unsigned      DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];

  logic              clr_q;
  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              clr_start;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_wa;
  logic [DATA_W-1:0] mem_wd;
  logic [IDX_W-1:0]  rd_addr;
  logic              rd_fire;

  // Wipe sequencer: one entry per cycle, busy until the last is written.
  always_comb begin
    clr_start = clr_req & ~clr_q & ~busy_q;
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
      end
    end else if (clr_start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      clr_q  <= clr_req;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // Single write port shared by the wipe sequencer and the host.
  always_comb begin
    mem_we = busy_q | wr_en;
    mem_wa = busy_q ? cnt_q : wr_addr;
    mem_wd = busy_q ? '0 : wr_data;
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[mem_wa] <= mem_wd;
    end
  end

  // Read port: short index zero-extended, one register of latency.
  always_comb begin
    rd_addr = rd_short ? IDX_W'(rd_idx[L4_W-1:0]) : rd_idx;
    rd_fire = rd_vld & gate_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= rd_fire;
      if (rd_fire) begin
        out_data <= mem[rd_addr];
      end
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/dual_palette_lut.sv
module dual_palette_lut
  import lut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned L4_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic              direct_mode,
  input  logic              bus_wr,
  input  logic [IDX_W+3:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bg_clr,
  input  logic              fg_clr,
  input  logic              bg_ptr_rst,
  input  logic              fg_ptr_rst,
  input  logic              bg_vld,
  input  logic [IDX_W-1:0]  bg_idx,
  input  logic              bg_short,
  input  logic              fg_vld,
  input  logic [IDX_W-1:0]  fg_idx,
  input  logic              fg_short,
  output logic              bg_argb_vld,
  output logic [DATA_W-1:0] bg_argb,
  output logic              fg_argb_vld,
  output logic [DATA_W-1:0] fg_argb,
  output logic              bg_busy,
  output logic              fg_busy
);

  logic [NUM_TBL-1:0]              clr_v, ptr_rst_v, vld_v, short_v;
  logic [NUM_TBL-1:0]              busy_v, ovld_v, we_v;
  logic [NUM_TBL-1:0][IDX_W-1:0]   idx_v, waddr_v;
  logic [NUM_TBL-1:0][DATA_W-1:0]  odata_v;
  logic [DATA_W-1:0]               wdata;

  always_comb begin
    clr_v[TBL_BACK]     = bg_clr;
    clr_v[TBL_FORE]     = fg_clr;
    ptr_rst_v[TBL_BACK] = bg_ptr_rst;
    ptr_rst_v[TBL_FORE] = fg_ptr_rst;
    vld_v[TBL_BACK]     = bg_vld;
    vld_v[TBL_FORE]     = fg_vld;
    short_v[TBL_BACK]   = bg_short;
    short_v[TBL_FORE]   = fg_short;
    idx_v[TBL_BACK]     = bg_idx;
    idx_v[TBL_FORE]     = fg_idx;
  end

  lut_host_port #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_en     (gate_en),
    .direct_mode (direct_mode),
    .wr_en       (bus_wr),
    .wr_addr     (bus_addr),
    .wr_data     (bus_wdata),
    .ptr_rst     (ptr_rst_v),
    .busy        (busy_v),
    .tbl_we      (we_v),
    .tbl_waddr   (waddr_v),
    .tbl_wdata   (wdata)
  );

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_bank
    lut_bank #(
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W),
      .L4_W   (L4_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_en  (gate_en),
      .clr_req  (clr_v[t]),
      .wr_en    (we_v[t]),
      .wr_addr  (waddr_v[t]),
      .wr_data  (wdata),
      .rd_vld   (vld_v[t]),
      .rd_idx   (idx_v[t]),
      .rd_short (short_v[t]),
      .out_vld  (ovld_v[t]),
      .out_data (odata_v[t]),
      .busy     (busy_v[t])
    );
  end

  assign bg_argb_vld = ovld_v[TBL_BACK];
  assign bg_argb     = odata_v[TBL_BACK];
  assign fg_argb_vld = ovld_v[TBL_FORE];
  assign fg_argb     = odata_v[TBL_FORE];
  assign bg_busy     = busy_v[TBL_BACK];
  assign fg_busy     = busy_v[TBL_FORE];

endmodule

// File: rtl/lut_checker.sv
module lut_checker #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic              bg_vld,
  input logic              fg_vld,
  input logic              bg_clr,
  input logic              fg_clr,
  input logic              bg_argb_vld,
  input logic              fg_argb_vld,
  input logic [DATA_W-1:0] bg_argb,
  input logic [DATA_W-1:0] fg_argb,
  input logic              bg_busy,
  input logic              fg_busy
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic             arm_q;
  logic [IDX_W:0]   bg_run, fg_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      bg_run <= '0;
      fg_run <= '0;
    end else begin
      arm_q  <= 1'b1;
      bg_run <= bg_busy ? bg_run + 1'b1 : '0;
      fg_run <= fg_busy ? fg_run + 1'b1 : '0;
    end
  end

  AST_BG_VLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && bg_argb_vld) |-> $past(gate_en && bg_vld)); // R6
  AST_FG_VLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && fg_argb_vld) |-> $past(gate_en && fg_vld)); // R8
  AST_BG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !$past(gate_en && bg_vld)) |-> $stable(bg_argb)); // R9
  AST_FG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !$past(gate_en && fg_vld)) |-> $stable(fg_argb)); // R9
  AST_BG_WIPE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bg_busy) |-> (bg_run == (IDX_W+1)'(DEPTH))); // R5
  AST_FG_WIPE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fg_busy) |-> (fg_run == (IDX_W+1)'(DEPTH))); // R5
  AST_BG_WIPE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bg_busy |-> (bg_run < (IDX_W+1)'(DEPTH))); // R5
  AST_FG_WIPE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fg_busy) |-> $past(fg_clr)); // R5
  AST_BG_WIPE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_busy) |-> $past(bg_clr)); // R5

endmodule

bind dual_palette_lut lut_checker #(
  .IDX_W  (IDX_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_en     (gate_en),
  .bg_vld      (bg_vld),
  .fg_vld      (fg_vld),
  .bg_clr      (bg_clr),
  .fg_clr      (fg_clr),
  .bg_argb_vld (bg_argb_vld),
  .fg_argb_vld (fg_argb_vld),
  .bg_argb     (bg_argb),
  .fg_argb     (fg_argb),
  .bg_busy     (bg_busy),
  .fg_busy     (fg_busy)
);

// File: tb/dual_palette_lut_test.sv
`timescale 1ns/1ps
module dual_palette_lut_test;

  logic        clk, rst_n, gate_en, direct_mode, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bg_clr, fg_clr, bg_ptr_rst, fg_ptr_rst;
  logic        bg_vld, bg_short, fg_vld, fg_short;
  logic [7:0]  bg_idx, fg_idx;
  logic        bg_argb_vld, fg_argb_vld, bg_busy, fg_busy;
  logic [31:0] bg_argb, fg_argb;

  int n_cmp = 0;
  int n_bad = 0;

  dual_palette_lut uut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .direct_mode(direct_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bg_clr(bg_clr), .fg_clr(fg_clr), .bg_ptr_rst(bg_ptr_rst), .fg_ptr_rst(fg_ptr_rst),
    .bg_vld(bg_vld), .bg_idx(bg_idx), .bg_short(bg_short),
    .fg_vld(fg_vld), .fg_idx(fg_idx), .fg_short(fg_short),
    .bg_argb_vld(bg_argb_vld), .bg_argb(bg_argb),
    .fg_argb_vld(fg_argb_vld), .fg_argb(fg_argb),
    .bg_busy(bg_busy), .fg_busy(fg_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector fields: [17] palette (1 = fg), [16] short index, [15:8] index, [7:0] entry expected.
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b0, 8'd0,   8'd0},
    {1'b0, 1'b0, 8'd255, 8'd255},
    {1'b1, 1'b0, 8'd0,   8'd0},
    {1'b1, 1'b0, 8'd200, 8'd200},
    {1'b0, 1'b1, 8'hA3,  8'd3},
    {1'b1, 1'b1, 8'hFF,  8'd15},
    {1'b0, 1'b1, 8'h0F,  8'd15},
    {1'b1, 1'b0, 8'd128, 8'd128}
  };

  function automatic logic [31:0] col(input bit tbl, input logic [7:0] i);
    return tbl ? {8'hF0, ~i, i, 8'h5A} : {8'hB0, i, ~i, i};
  endfunction

  function automatic logic [31:0] fill(input logic [7:0] i);
    return {8'hC3, i, i, i};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic look(input bit tbl, input logic [7:0] i, input bit s,
                      output logic [31:0] d, output logic v);
    @(negedge clk);
    if (tbl) begin fg_vld = 1'b1; fg_idx = i; fg_short = s; end
    else     begin bg_vld = 1'b1; bg_idx = i; bg_short = s; end
    @(negedge clk);
    d = tbl ? fg_argb : bg_argb;
    v = tbl ? fg_argb_vld : bg_argb_vld;
    bg_vld = 1'b0; fg_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        v;
    logic [31:0] held;
    int          cnt;
    rst_n = 1'b0; gate_en = 1'b1; direct_mode = 1'b1; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; bg_clr = 1'b0; fg_clr = 1'b0;
    bg_ptr_rst = 1'b0; fg_ptr_rst = 1'b0; bg_vld = 1'b0; fg_vld = 1'b0;
    bg_idx = '0; fg_idx = '0; bg_short = 1'b0; fg_short = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bg_argb", bg_argb, 32'h0);
    chk("R1 fg_argb", fg_argb, 32'h0);
    chk("R1 valids/busy", {28'h0, bg_argb_vld, fg_argb_vld, bg_busy, fg_busy}, 32'h0);

    // R2 direct load of both palettes
    for (int i = 0; i < 256; i++) begin
      wr(12'h400 + 12'(i * 4), col(1'b0, 8'(i)));
      wr(12'h800 + 12'(i * 4), col(1'b1, 8'(i)));
    end

    // R6 R7 R11 vector walk
    for (int k = 0; k < 8; k++) begin
      look(VEC[k][17], VEC[k][15:8], VEC[k][16], d, v);
      chk($sformatf("R6/R7/R11 vec%0d data", k), d, col(VEC[k][17], VEC[k][7:0]));
      chk($sformatf("R6 vec%0d valid", k), {31'h0, v}, 32'h1);
    end

    // R2 ignored windows and misaligned address
    wr(12'h000 + 12'd20, 32'hDEAD_0001);
    wr(12'hC00 + 12'd20, 32'hDEAD_0002);
    wr(12'h400 + 12'd24 + 12'd1, 32'hDEAD_0003);
    look(1'b0, 8'd5, 1'b0, d, v); chk("R2 bg5 untouched", d, col(1'b0, 8'd5));
    look(1'b1, 8'd5, 1'b0, d, v); chk("R2 fg5 untouched", d, col(1'b1, 8'd5));
    look(1'b0, 8'd6, 1'b0, d, v); chk("R2 misaligned ignored", d, col(1'b0, 8'd6));

    // R9 hold after lookup
    held = bg_argb;
    repeat (3) @(negedge clk);
    chk("R9 bg hold", bg_argb, held);
    chk("R9 bg valid low", {31'h0, bg_argb_vld}, 32'h0);

    // R3 streaming mode with wrap
    direct_mode = 1'b0;
    for (int k = 0; k < 3; k++) wr(12'h4FC, 32'h1111_0000 + 32'(k));
    for (int i = 3; i < 256; i++) wr(12'h400, fill(8'(i)));
    wr(12'h400, 32'h2222_0000);
    look(1'b0, 8'd2, 1'b0, d, v);   chk("R3 entry2", d, 32'h1111_0002);
    look(1'b0, 8'd255, 1'b0, d, v); chk("R3 entry255", d, fill(8'd255));
    look(1'b0, 8'd0, 1'b0, d, v);   chk("R3 wrap to entry0", d, 32'h2222_0000);

    // R4 pointer reset blocks the write in the same cycle
    @(negedge clk);
    bg_ptr_rst = 1'b1; bus_wr = 1'b1; bus_addr = 12'h400; bus_wdata = 32'h3333_3333;
    @(negedge clk);
    bg_ptr_rst = 1'b0; bus_wr = 1'b0;
    wr(12'h400, 32'h4444_0000);
    look(1'b0, 8'd0, 1'b0, d, v); chk("R4 pointer back to 0", d, 32'h4444_0000);
    look(1'b0, 8'd1, 1'b0, d, v); chk("R4 blocked write dropped", d, 32'h1111_0001);
    wr(12'h800, 32'h5555_0000);
    look(1'b1, 8'd0, 1'b0, d, v); chk("R3 fg stream entry0", d, 32'h5555_0000);
    look(1'b1, 8'd1, 1'b0, d, v); chk("R11 fg entry1 kept", d, col(1'b1, 8'd1));

    // R10 same-cycle write and lookup of one entry
    direct_mode = 1'b1;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h428; bus_wdata = 32'h6666_6666;
    bg_vld = 1'b1; bg_idx = 8'd10; bg_short = 1'b0;
    @(negedge clk);
    chk("R10 old word returned", bg_argb, fill(8'd10));
    bus_wr = 1'b0; bg_vld = 1'b0;
    look(1'b0, 8'd10, 1'b0, d, v); chk("R10 new word later", d, 32'h6666_6666);

    // R8 gate low
    held = bg_argb;
    gate_en = 1'b0;
    wr(12'h400 + 12'd80, 32'h7777_7777);
    look(1'b0, 8'd20, 1'b0, d, v);
    chk("R8 no valid when gated", {31'h0, v}, 32'h0);
    chk("R8 colour held when gated", d, held);
    gate_en = 1'b1;
    look(1'b0, 8'd20, 1'b0, d, v); chk("R8 gated write ignored", d, fill(8'd20));

    // R5 foreground wipe, with a host write landing mid-wipe
    @(negedge clk); fg_clr = 1'b1;
    @(negedge clk); fg_clr = 1'b0;
    cnt = 0;
    while (fg_busy && cnt < 1000) begin
      cnt++;
      if (cnt == 5) begin bus_wr = 1'b1; bus_addr = 12'h800 + 12'd120; bus_wdata = 32'h8888_8888; end
      if (cnt == 6) bus_wr = 1'b0;
      @(negedge clk);
    end
    bus_wr = 1'b0;
    chk("R5 busy length", 32'(cnt), 32'd256);
    look(1'b1, 8'd30, 1'b0, d, v);  chk("R5 write during wipe ignored", d, 32'h0);
    look(1'b1, 8'd255, 1'b0, d, v); chk("R5 fg255 cleared", d, 32'h0);
    look(1'b1, 8'd0, 1'b0, d, v);   chk("R5 fg0 cleared", d, 32'h0);
    look(1'b0, 8'd100, 1'b0, d, v); chk("R5 bg untouched", d, fill(8'd100));
    chk("R5 bg never busy", {31'h0, bg_busy}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule